// File: doc/BRIEF.md
# Streaming FM Phase Modulator

This block produces a frequency-modulated sine wave by direct digital synthesis. Each clock it may accept one signed message sample. It turns that sample into a phase step. The step is a fixed carrier increment plus a peak-deviation increment weighted by the sample. The step is added into a wrapping phase accumulator. The top bits of the accumulator then address a sine table that is built when the design elaborates. Because the accumulator sums the steps, it integrates the instantaneous frequency. The output frequency therefore swings about the carrier in proportion to the message.

The carrier and deviation increments are parameters. With the defaults and a 200 MHz sample clock, one increment LSB is about 0.3725 Hz. An increment of 268 then gives a carrier near 100 Hz, and a deviation of 134 gives a swing of about ±50 Hz. The accumulated phase is also brought out next to the sine sample, so that the frequency actually applied can be observed.

Top module: `fm_phase_mod`

## Requirements
- R1: For each accepted sample m (32-bit two's complement, where ±2^31 stands for ±1), the phase step is CAR_INC + floor((2·DEV_INC·m + 2^31) / 2^32). This is an arithmetic shift that keeps the product bits above bit 31, rounded to nearest.
- R2: The accumulator is PHASE_W bits wide (29 by default). It adds one step per accepted sample and wraps modulo 2^PHASE_W. While `msg_valid` is low it holds its value, and `phase_out` does not change.
- R3: With the default increments, a constant message of 0x7FFFFFFF advances the phase by 402 per sample, 0x80000000 by 134, and 0 by 268.
- R4: `sin_valid` equals `msg_valid` from exactly three clocks earlier. In that cycle `phase_out` shows the accumulator value that includes the sample.
- R5: `sin_data` is round(32767·sin(2π·k/1024)), where k is the top 10 bits of `phase_out`, as a 16-bit signed value. It is never −32768.
- R6: A synchronous reset clears the accumulator, `phase_out` and `sin_data` to zero and drops `sin_valid`. Samples still in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_valid | input | 1 | Message sample present this cycle |
| msg_data | input | 32 | Signed message sample |
| sin_valid | output | 1 | Output sample present this cycle |
| sin_data | output | 16 | Signed sine sample |
| phase_out | output | 29 | Accumulated phase for this output sample |

## Verification
The hardest condition to reach from the ports is accumulator wraparound. With the default increments it takes more than a million samples, so a second instance with increments near 2^27 runs from the same stimulus and wraps every few samples. Its phase is checked against a modulo model on every output. Full-scale samples of both signs and exact half-scale values check the rounding edges of the step. A reset asserted while samples are still in the pipeline shows that none of them reappears.

// File: rtl/fm_phase_mod.sv
module fm_phase_mod #(
  parameter int PHASE_W = 29,
  parameter int MSG_W   = 32,
  parameter int DEV_W   = 16,
  parameter int CAR_INC = 268,
  parameter int DEV_INC = 134,
  parameter int LUT_AW  = 10,
  parameter int OUT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     msg_valid,
  input  logic [MSG_W-1:0]         msg_data,
  output logic                     sin_valid,
  output logic signed [OUT_W-1:0]  sin_data,
  output logic [PHASE_W-1:0]       phase_out
);
  localparam int PROD_W = MSG_W + DEV_W + 1;
  localparam int LUT_N  = 1 << LUT_AW;
  localparam real AMP   = real'((1 << (OUT_W - 1)) - 1);
  localparam real TWO_PI = 6.283185307179586;
  localparam logic signed [DEV_W:0] DEV2 = (DEV_W + 1)'(2 * DEV_INC);
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (MSG_W - 1);

  function automatic logic signed [OUT_W-1:0] sine_at(input int k);
    real a;
    a = AMP * $sin(TWO_PI * real'(k) / real'(LUT_N));
    if (a >= 0.0) a = a + 0.5;
    else          a = a - 0.5;
    return OUT_W'($rtoi(a));
  endfunction

  logic signed [OUT_W-1:0] lut [LUT_N];
  for (genvar i = 0; i < LUT_N; i++) begin : g_lut
    assign lut[i] = sine_at(i);
  end

  logic signed [PROD_W-1:0] msg_x, dev_x, rnd;
  logic [PHASE_W-1:0] inc_d, inc_q, acc;
  logic v1, v2;

  assign msg_x = PROD_W'($signed(msg_data));
  assign dev_x = PROD_W'(DEV2);
  assign rnd   = msg_x * dev_x + HALF;
  assign inc_d = PHASE_W'(CAR_INC) + PHASE_W'(rnd >>> MSG_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      v1    <= 1'b0;
      inc_q <= '0;
      v2    <= 1'b0;
      acc   <= '0;
      sin_valid <= 1'b0;
      sin_data  <= '0;
      phase_out <= '0;
    end else begin
      v1 <= msg_valid;
      if (msg_valid) inc_q <= inc_d;
      v2 <= v1;
      if (v1) acc <= acc + inc_q;
      sin_valid <= v2;
      if (v2) begin
        phase_out <= acc;
        sin_data  <= lut[acc[PHASE_W-1 -: LUT_AW]];
      end
    end
  end
endmodule

// File: rtl/fm_phase_mod_chk.sv
module fm_phase_mod_chk #(
  parameter int PHASE_W = 29,
  parameter int MSG_W   = 32,
  parameter int DEV_W   = 16,
  parameter int CAR_INC = 268,
  parameter int DEV_INC = 134,
  parameter int OUT_W   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    msg_valid,
  input logic [MSG_W-1:0]        msg_data,
  input logic                    sin_valid,
  input logic signed [OUT_W-1:0] sin_data,
  input logic [PHASE_W-1:0]      phase_out
);
  localparam int PROD_W = MSG_W + DEV_W + 1;
  localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  logic [2:0] vh;
  logic [MSG_W-1:0] m1, m2, m3;
  logic [PHASE_W-1:0] last_ph, want;
  logic signed [PROD_W-1:0] prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      vh <= '0; m1 <= '0; m2 <= '0; m3 <= '0; last_ph <= '0;
    end else begin
      vh <= {vh[1:0], msg_valid};
      if (msg_valid) m1 <= msg_data;
      m2 <= m1;
      m3 <= m2;
      if (sin_valid) last_ph <= phase_out;
    end
  end

  assign prod = PROD_W'($signed(m3)) * PROD_W'(2 * DEV_INC) + (PROD_W'(1) << (MSG_W - 1));
  assign want = last_ph + PHASE_W'(CAR_INC) + PHASE_W'(prod >>> MSG_W);

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    sin_valid |-> phase_out == want);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !sin_valid |-> phase_out == last_ph);
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    sin_valid == vh[2]);
  p_sine_range_r5: assert property (@(posedge clk) disable iff (rst)
    sin_valid |-> sin_data != MOST_NEG);
  p_reset_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sin_valid && phase_out == '0 && sin_data == '0));
endmodule

bind fm_phase_mod fm_phase_mod_chk #(
  .PHASE_W(PHASE_W), .MSG_W(MSG_W), .DEV_W(DEV_W),
  .CAR_INC(CAR_INC), .DEV_INC(DEV_INC), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_data(msg_data),
  .sin_valid(sin_valid), .sin_data(sin_data), .phase_out(phase_out)
);

// File: tb/fm_phase_mod_tb.sv
module fm_phase_mod_tb;
  localparam longint MASK = (64'sd1 <<< 29) - 1;
  localparam longint W_CAR = 100000000;
  localparam longint W_DEV = 50000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mv = 1'b0;
  logic [31:0] md = '0;
  logic sv0, sv1;
  logic signed [15:0] sd0, sd1;
  logic [28:0] ph0, ph1;

  always #4 clk = ~clk;

  fm_phase_mod u_dut (
    .clk(clk), .rst(rst), .msg_valid(mv), .msg_data(md),
    .sin_valid(sv0), .sin_data(sd0), .phase_out(ph0));

  fm_phase_mod #(.DEV_W(27), .CAR_INC(100000000), .DEV_INC(50000000)) u_dut_wrap (
    .clk(clk), .rst(rst), .msg_valid(mv), .msg_data(md),
    .sin_valid(sv1), .sin_data(sd1), .phase_out(ph1));

  int checks = 0, fails = 0, wraps = 0;
  bit done = 1'b0;
  longint q0[$], q1[$];
  longint mph0 = 0, mph1 = 0;

  function automatic longint dev_term(longint m, longint dev);
    return (2 * dev * m + 64'sd2147483648) >>> 32;
  endfunction

  function automatic longint sine_ref(longint ph);
    longint idx;
    real a;
    idx = ph >> 19;
    a = 32767.0 * $sin(6.283185307179586 * real'(idx) / 1024.0);
    return (a >= 0.0) ? longint'($rtoi(a + 0.5)) : longint'($rtoi(a - 0.5));
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_sine(input longint sd, input longint ph);
    longint e;
    e = sine_ref(ph);
    chk(sd - e <= 1 && e - sd <= 1 && sd != -32768, "R5 sine value", sd, e);
  endtask

  // monitor: scoreboard pop and compare, away from the clock edge
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (sv0) begin
        if (q0.size() == 0) chk(1'b0, "R4 valid without input", 1, 0);
        else begin
          mph0 = (mph0 + q0.pop_front()) & MASK;
          chk(longint'(ph0) == mph0, "R1 phase step", longint'(ph0), mph0);
          check_sine(longint'(sd0), longint'(ph0));
        end
      end else chk(longint'(ph0) == mph0, "R2 hold without valid", longint'(ph0), mph0);
      if (sv1) begin
        if (q1.size() == 0) chk(1'b0, "R4 valid without input (wrap)", 1, 0);
        else begin
          longint nx;
          nx = (mph1 + q1.pop_front()) & MASK;
          if (nx < mph1) wraps++;
          mph1 = nx;
          chk(longint'(ph1) == mph1, "R2 wrapping phase", longint'(ph1), mph1);
          check_sine(longint'(sd1), longint'(ph1));
        end
      end
    end
  end

  task automatic send(input longint m);
    @(negedge clk);
    mv = 1'b1;
    md = m[31:0];
    q0.push_back(268 + dev_term(m, 134));
    q1.push_back(W_CAR + dev_term(m, W_DEV));
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      mv = 1'b0;
    end
  endtask

  task automatic run_step(input longint m, input longint exp, input string tag);
    longint a, b;
    fork
      repeat (12) send(m);
      begin
        repeat (8) @(posedge clk);
        #2 a = longint'(ph0);
        @(posedge clk);
        #2 b = longint'(ph0);
        chk(sv0 && ((b - a) & MASK) == exp, tag, (b - a) & MASK, exp);
      end
    join
    idle(4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(sv0 == 1'b0, "R6 reset valid", longint'(sv0), 0);
    chk(ph0 == '0, "R6 reset phase", longint'(ph0), 0);
    chk(sd0 == '0, "R6 reset sine", longint'(sd0), 0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);

    run_step(64'sh7FFFFFFF, 402, "R3 +full scale step");
    run_step(-64'sh80000000, 134, "R3 -full scale step");
    run_step(0, 268, "R3 zero message step");
    run_step(64'sh40000000, 335, "R1 half scale step");
    run_step(-64'sh40000000, 201, "R1 negative half scale step");

    begin
      logic [31:0] lf;
      lf = 32'hACE1_1234;
      for (int i = 0; i < 300; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        send(longint'($signed(lf)));
        if (i % 7 == 3) idle(1 + i % 3);
      end
    end
    idle(5);

    send(0);
    @(negedge clk);
    mv = 1'b0;
    @(posedge clk);
    #2 chk(sv0 == 1'b0, "R4 no output after two edges", longint'(sv0), 0);
    @(posedge clk);
    #2 chk(sv0 == 1'b1, "R4 output on third edge", longint'(sv0), 1);
    idle(4);

    send(64'sh7FFFFFFF);
    send(64'sh12345678);
    @(negedge clk);
    rst = 1'b1;
    mv = 1'b0;
    q0.delete();
    q1.delete();
    mph0 = 0;
    mph1 = 0;
    @(posedge clk);
    #2;
    chk(sv0 == 1'b0 && sv1 == 1'b0, "R6 mid-stream reset valid", longint'(sv0), 0);
    chk(ph0 == '0 && ph1 == '0, "R6 mid-stream reset phase", longint'(ph0), 0);
    @(negedge clk);
    rst = 1'b0;
    idle(6);
    run_step(0, 268, "R6 restart from zero step");
    chk(longint'(ph0) == 268 * 12, "R6 phase restarts at zero", longint'(ph0), 268 * 12);

    idle(6);
    chk(q0.size() == 0 && q1.size() == 0, "R4 every sample produced", q0.size(), 0);
    chk(wraps > 10, "R2 wraparound exercised", wraps, 11);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule